// File: doc/BRIEF.md
# Shared Pin I/O Pipeline for Multiple Cores

This block sits between a group of processor cores and one shared bank of general-purpose pins. Each core owns an output-value register and a drive-enable register. Both are loaded on the last clock of the instruction that writes them. A shared hub stage ORs the registers of all cores together and registers the result once before it reaches the pins. On the return path, each pin is registered at the pad. It then passes through a per-pin choice of direct path or three-sample majority filter, and is registered again in the hub before it fans out to every core.

A core is modelled only by two strobes. The first marks the first clock of an instruction. The second marks the last clock. A core captures pin data in one of two places. The pin-test capture is taken on the first-clock strobe. The operand capture is taken on the last-clock strobe, so it serves the instruction that follows. Every stage is a register, so each latency is a fixed number of clocks at any clock frequency. Software can therefore count cycles between driving a pin and reading it back.

Top module: `pin_io_pipe`

## Requirements
- R1: A core's output-value and drive-enable registers load their data inputs only in a cycle where both its last-clock strobe and its write strobe are high. A write strobe without the last-clock strobe leaves the registers unchanged, and so leaves the pins unchanged.
- R2: After a write whose last-clock strobe is in cycle t, `pin_out` and `pin_oe` show the new value from cycle t+2 onward, and still show the old value in cycle t+1.
- R3: Each bit of `pin_out` is the OR of that bit across all cores' output-value registers. Each bit of `pin_oe` is the OR of that bit across all drive-enable registers. A pin stays high while any core still drives a 1 on it.
- R4: With the filter off for a pin, a first-clock strobe in cycle t stores, in that core's pin-test capture, the `pin_in` value present during cycle t-2. The capture holds until the core's next first-clock strobe.
- R5: A last-clock strobe in cycle t stores, in that core's operand capture, the same two-cycles-old input value. Measured from the first clock of the following instruction, the value is three cycles old. The capture holds until the core's next last-clock strobe.
- R6: With `pin_filt_sel` bit p set to 1, a capture in cycle t sees the majority of the `pin_in` bit p values from cycles t-2, t-3 and t-4. A one-cycle pulse is never seen. A lasting step arrives exactly one cycle later than on the direct path.
- R7: While `rst_n` is low at a clock edge, every pipeline register clears to 0. After that edge, `pin_out`, `pin_oe` and all captures read 0, so every pin is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| core_get | input | N_CORES | Per core: first clock of an instruction |
| core_go | input | N_CORES | Per core: last clock of an instruction |
| core_wr | input | N_CORES | Per core: the instruction writes the pin registers |
| core_out_d | input | N_CORES*N_PINS | Output values to write; core i uses bits [i*N_PINS +: N_PINS] |
| core_dir_d | input | N_CORES*N_PINS | Drive enables to write, packed the same way |
| pin_filt_sel | input | N_PINS | Per pin: 0 for the direct path, 1 for the majority filter |
| pin_in | input | N_PINS | Pin levels from the pads |
| pin_out | output | N_PINS | Merged output value to the pads |
| pin_oe | output | N_PINS | Merged drive enable to the pads |
| core_test_q | output | N_CORES*N_PINS | Per-core pin-test capture |
| core_opnd_q | output | N_CORES*N_PINS | Per-core operand capture |

## Verification
The bench builds the block with four cores and eight pins. Four cores are enough to stagger the two capture strobes across two cores in the same cycles. They are also enough to release a pin from one core while another still holds it high, and to run randomly colliding writes. Eight pins let the filter be on for some pins and off for others during the same run. A loopback from `pin_out` to `pin_in` is switched in for parts of the run, so the drive-to-readback distance is measured end to end.

// File: rtl/pin_io_pkg.sv
// Package pin_io_pkg
// Shared helpers for the pin I/O pipeline.
// Assumes: nothing beyond synthesizable functions.
package pin_io_pkg;

    // Bitwise two-of-three vote across three sample vectors.
    function automatic logic [63:0] vote3(input logic [63:0] a,
                                          input logic [63:0] b,
                                          input logic [63:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/pio_in_stage.sv
// Module pio_in_stage
// Registers each pin at the pad and offers, per pin, either that sample or
// a vote over the last three samples. The output is combinational from
// registers. The hub adds the next register stage.
// Assumes: pin_i is already synchronous to clk; sel_i is quasi-static.
module pio_in_stage #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic [N_PINS-1:0] sel_i,
    output logic [N_PINS-1:0] val_o
);
    import pin_io_pkg::*;

    localparam int HIST = 3;

    logic [N_PINS-1:0] smp_q [HIST];

    // Pad register followed by a two-deep sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < HIST; k++) smp_q[k] <= '0;
        end else begin
            smp_q[0] <= pin_i;
            for (int k = 1; k < HIST; k++) smp_q[k] <= smp_q[k-1];
        end
    end

    // Per-pin choice of direct sample or majority vote.
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic voted;
        always_comb begin
            voted = smp_q[0][p] & smp_q[1][p]
                  | smp_q[0][p] & smp_q[2][p]
                  | smp_q[1][p] & smp_q[2][p];
            val_o[p] = sel_i[p] ? voted : smp_q[0][p];
        end
    end

endmodule

// File: rtl/pio_hub.sv
// Module pio_hub
// The shared stage. It ORs the output-value and drive-enable registers of
// all cores and registers the result toward the pins. It also registers
// the selected input value once before fan-out to the cores.
// Assumes: core vectors are packed with core i at [i*N_PINS +: N_PINS].
module pio_hub #(
    parameter int N_CORES = 4,
    parameter int N_PINS  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CORES*N_PINS-1:0] out_all_i,
    input  logic [N_CORES*N_PINS-1:0] dir_all_i,
    input  logic [N_PINS-1:0]         in_val_i,
    output logic [N_PINS-1:0]         pin_out_o,
    output logic [N_PINS-1:0]         pin_oe_o,
    output logic [N_PINS-1:0]         in_hub_o
);
    logic [N_PINS-1:0] or_out;
    logic [N_PINS-1:0] or_dir;

    // OR-merge of every core's value and enable vectors.
    always_comb begin
        or_out = '0;
        or_dir = '0;
        for (int c = 0; c < N_CORES; c++) begin
            or_out = or_out | out_all_i[c*N_PINS +: N_PINS];
            or_dir = or_dir | dir_all_i[c*N_PINS +: N_PINS];
        end
    end

    // One register stage in each direction; data and enable move together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out_o <= '0;
            pin_oe_o  <= '0;
            in_hub_o  <= '0;
        end else begin
            pin_out_o <= or_out;
            pin_oe_o  <= or_dir;
            in_hub_o  <= in_val_i;
        end
    end

endmodule

// File: rtl/pio_core_port.sv
// Module pio_core_port
// One core's view of the pins. It holds the output-value and drive-enable
// registers, written on the last clock of an instruction. It also holds
// two input captures: one taken on the first clock and one on the last.
// Assumes: get_i/go_i come straight from the core's sequencer.
module pio_core_port #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              get_i,
    input  logic              go_i,
    input  logic              wr_i,
    input  logic [N_PINS-1:0] out_d,
    input  logic [N_PINS-1:0] dir_d,
    input  logic [N_PINS-1:0] hub_in_i,
    output logic [N_PINS-1:0] out_q,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] test_q,
    output logic [N_PINS-1:0] opnd_q
);
    // Output registers load only at the end of a writing instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (go_i && wr_i) begin
            out_q <= out_d;
            dir_q <= dir_d;
        end
    end

    // Pin-test capture on the first clock of an instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)     test_q <= '0;
        else if (get_i) test_q <= hub_in_i;
    end

    // Operand capture on the last clock, used by the next instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)    opnd_q <= '0;
        else if (go_i) opnd_q <= hub_in_i;
    end

    // R1: no last-clock strobe, no change to the drive registers.
    p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> ($stable(out_q) && $stable(dir_q)));

    // R4: pin-test capture holds between first-clock strobes.
    p_test_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !get_i |=> $stable(test_q));

    // R5: operand capture holds between last-clock strobes.
    p_opnd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> $stable(opnd_q));

endmodule

// File: rtl/pin_io_pipe.sv
// Module pin_io_pipe
// Top of the shared pin pipeline. It has one port block per core, one
// shared hub stage and one pad input stage. All latencies are counted in
// registers, never in gate delay.
// Assumes: synchronous active-low reset; pads are outside this block.
module pin_io_pipe #(
    parameter int N_CORES = 4,
    parameter int N_PINS  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CORES-1:0]        core_get,
    input  logic [N_CORES-1:0]        core_go,
    input  logic [N_CORES-1:0]        core_wr,
    input  logic [N_CORES*N_PINS-1:0] core_out_d,
    input  logic [N_CORES*N_PINS-1:0] core_dir_d,
    input  logic [N_PINS-1:0]         pin_filt_sel,
    input  logic [N_PINS-1:0]         pin_in,
    output logic [N_PINS-1:0]         pin_out,
    output logic [N_PINS-1:0]         pin_oe,
    output logic [N_CORES*N_PINS-1:0] core_test_q,
    output logic [N_CORES*N_PINS-1:0] core_opnd_q
);
    localparam int VEC_W = N_CORES * N_PINS;

    logic [VEC_W-1:0]  out_all;
    logic [VEC_W-1:0]  dir_all;
    logic [N_PINS-1:0] in_val;
    logic [N_PINS-1:0] in_hub;

    // Pad-side input register and per-pin filter choice.
    pio_in_stage #(.N_PINS(N_PINS)) u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_in),
        .sel_i (pin_filt_sel),
        .val_o (in_val)
    );

    // Shared merge and register stage.
    pio_hub #(.N_CORES(N_CORES), .N_PINS(N_PINS)) u_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_all_i (out_all),
        .dir_all_i (dir_all),
        .in_val_i  (in_val),
        .pin_out_o (pin_out),
        .pin_oe_o  (pin_oe),
        .in_hub_o  (in_hub)
    );

    // One port block per core.
    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        pio_core_port #(.N_PINS(N_PINS)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .get_i    (core_get[c]),
            .go_i     (core_go[c]),
            .wr_i     (core_wr[c]),
            .out_d    (core_out_d[c*N_PINS +: N_PINS]),
            .dir_d    (core_dir_d[c*N_PINS +: N_PINS]),
            .hub_in_i (in_hub),
            .out_q    (out_all[c*N_PINS +: N_PINS]),
            .dir_q    (dir_all[c*N_PINS +: N_PINS]),
            .test_q   (core_test_q[c*N_PINS +: N_PINS]),
            .opnd_q   (core_opnd_q[c*N_PINS +: N_PINS])
        );
    end

    // R7: a reset edge leaves the pins undriven and low.
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0));

    // R2: if no core changed its registers two edges back, the pins hold.
    p_pin_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_go & core_wr) == '0) |=> ##1 ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/pin_io_pipe_bench.sv
// Bench for pin_io_pipe: a per-cycle history model derived from the stated
// latencies, random traffic, and directed latency, merge and filter cases.
module pin_io_pipe_bench;
    localparam int NC   = 4;
    localparam int NP   = 8;
    localparam int VW   = NC * NP;
    localparam int MAXC = 4096;
    localparam int OFS  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0] core_get = '0, core_go = '0, core_wr = '0;
    logic [VW-1:0] core_out_d = '0, core_dir_d = '0;
    logic [NP-1:0] pin_filt_sel = '0, pin_drv = '0;
    logic          loop_en = 1'b0;
    logic [NP-1:0] pin_in, pin_out, pin_oe;
    logic [VW-1:0] core_test_q, core_opnd_q;

    assign pin_in = loop_en ? pin_out : pin_drv;

    always #2 clk = ~clk;

    pin_io_pipe #(.N_CORES(NC), .N_PINS(NP)) u_pin_io_pipe (
        .clk(clk), .rst_n(rst_n), .core_get(core_get), .core_go(core_go),
        .core_wr(core_wr), .core_out_d(core_out_d), .core_dir_d(core_dir_d),
        .pin_filt_sel(pin_filt_sel), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .core_test_q(core_test_q), .core_opnd_q(core_opnd_q)
    );

    int n_run = 0;
    int n_fail = 0;
    int cur = 0;
    bit finished = 1'b0;

    logic [NP-1:0] pin_h [MAXC+OFS];
    logic [NP-1:0] sel_h [MAXC+OFS];
    logic [VW-1:0] out_h [MAXC+OFS];
    logic [VW-1:0] dir_h [MAXC+OFS];
    logic [VW-1:0] m_test = '0, m_opnd = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cur, act, exp);
        end
    endtask

    // Value a capture made at the edge ending cycle c must hold (R4, R6).
    function automatic logic [NP-1:0] exp_in(input int c);
        logic [NP-1:0] a, b, d, s;
        a = pin_h[c-2+OFS]; b = pin_h[c-3+OFS]; d = pin_h[c-4+OFS];
        s = sel_h[c-1+OFS];
        return (s & ((a & b) | (a & d) | (b & d))) | (~s & a);
    endfunction

    // OR of all cores' slices (R3).
    function automatic logic [NP-1:0] or_cores(input logic [VW-1:0] v);
        logic [NP-1:0] r = '0;
        for (int i = 0; i < NC; i++) r = r | v[i*NP +: NP];
        return r;
    endfunction

    // Compare every output with the model; outputs reflect edge cur-1.
    task automatic check_all();
        string t;
        chk("R3 pin_out", 64'(pin_out), 64'(or_cores(out_h[cur-2+OFS])));
        chk("R2 pin_oe", 64'(pin_oe), 64'(or_cores(dir_h[cur-2+OFS])));
        t = (sel_h[cur-2+OFS] != '0 || sel_h[cur-3+OFS] != '0) ? "R6 test" : "R4 test";
        chk(t, 64'(core_test_q), 64'(m_test));
        chk("R5 opnd", 64'(core_opnd_q), 64'(m_opnd));
    endtask

    // One cycle: check, drive, record, advance the model.
    task automatic step(input logic [NC-1:0] g, input logic [NC-1:0] o,
                        input logic [NC-1:0] w, input logic [VW-1:0] od,
                        input logic [VW-1:0] dd, input logic [NP-1:0] pd,
                        input logic [NP-1:0] sl, input logic lp);
        logic [NP-1:0] ev;
        @(negedge clk);
        check_all();
        core_get = g; core_go = o; core_wr = w; core_out_d = od;
        core_dir_d = dd; pin_drv = pd; pin_filt_sel = sl; loop_en = lp;
        #1;
        pin_h[cur+OFS] = pin_in;
        sel_h[cur+OFS] = sl;
        ev = exp_in(cur);
        out_h[cur+OFS] = out_h[cur-1+OFS];
        dir_h[cur+OFS] = dir_h[cur-1+OFS];
        for (int i = 0; i < NC; i++) begin
            if (o[i] && w[i]) begin
                out_h[cur+OFS][i*NP +: NP] = od[i*NP +: NP];
                dir_h[cur+OFS][i*NP +: NP] = dd[i*NP +: NP];
            end
            if (g[i]) m_test[i*NP +: NP] = ev;
            if (o[i]) m_opnd[i*NP +: NP] = ev;
        end
        cur++;
    endtask

    task automatic idle(input logic [NP-1:0] pd, input logic [NP-1:0] sl, input logic lp);
        step('0, '0, '0, '0, '0, pd, sl, lp);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        for (int k = 0; k < MAXC + OFS; k++) begin
            pin_h[k] = '0; sel_h[k] = '0; out_h[k] = '0; dir_h[k] = '0;
        end
        core_out_d = '1; core_dir_d = '1; core_go = '1; core_wr = '1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7: reset cleared every register even with write strobes held high.
        chk("R7 pin_out", 64'(pin_out), 64'd0);
        chk("R7 pin_oe", 64'(pin_oe), 64'd0);
        chk("R7 test", 64'(core_test_q), 64'd0);
        chk("R7 opnd", 64'(core_opnd_q), 64'd0);
        core_out_d = '0; core_dir_d = '0; core_go = '0; core_wr = '0;
        rst_n = 1'b1;

        // R1: write strobe without the last-clock strobe is ignored.
        step(4'b0010, '0, 4'b0010, '1, '1, '0, '0, 1'b0);
        repeat (3) idle('0, '0, 1'b0);
        chk("R1 pin_out", 64'(pin_out), 64'd0);
        chk("R1 pin_oe", 64'(pin_oe), 64'd0);

        // R2/R4/R5: loopback from a core-0 write on pin 0.
        step(4'b0001, '0, '0, '0, '0, '0, '0, 1'b1);
        step('0, 4'b0001, 4'b0001, VW'(1), VW'(1), '0, '0, 1'b1);
        idle('0, '0, 1'b1);
        chk("R2 pin0 early", 64'(pin_out[0]), 64'd0);
        idle('0, '0, 1'b1);
        chk("R2 pin0 on time", 64'(pin_out[0]), 64'd1);
        chk("R2 oe0 on time", 64'(pin_oe[0]), 64'd1);
        step(4'b0100, 4'b1000, '0, '0, '0, '0, '0, 1'b1);
        step(4'b1000, 4'b0100, '0, '0, '0, '0, '0, 1'b1);
        idle('0, '0, 1'b1);
        chk("R4 core2 test old", 64'(core_test_q[2*NP]), 64'd0);
        chk("R5 core2 opnd new", 64'(core_opnd_q[2*NP]), 64'd1);
        chk("R5 core3 opnd old", 64'(core_opnd_q[3*NP]), 64'd0);
        chk("R4 core3 test new", 64'(core_test_q[3*NP]), 64'd1);

        // R3: pin 2 held by core 0 after core 1 releases it.
        step('0, 4'b0011, 4'b0011, {16'h0, 8'h04, 8'h05}, '0, '0, '0, 1'b0);
        step('0, 4'b0010, 4'b0010, '0, '0, '0, '0, 1'b0);
        idle('0, '0, 1'b0); idle('0, '0, 1'b0);
        chk("R3 pin2 held", 64'(pin_out[2]), 64'd1);
        step('0, 4'b0001, 4'b0001, '0, '0, '0, '0, 1'b0);
        idle('0, '0, 1'b0); idle('0, '0, 1'b0);
        chk("R3 pin2 released", 64'(pin_out[2]), 64'd0);

        // R6: filter on pin 1 rejects a one-cycle pulse, delays a step by one.
        repeat (4) step(4'b0001, '0, '0, '0, '0, '0, 8'h02, 1'b0);
        step(4'b0001, '0, '0, '0, '0, 8'h02, 8'h02, 1'b0);
        for (int k = 0; k < 5; k++) begin
            step(4'b0001, '0, '0, '0, '0, '0, 8'h02, 1'b0);
            chk("R6 pulse rejected", 64'(core_test_q[1]), 64'd0);
        end
        for (int k = 0; k < 5; k++) begin
            step(4'b0001, '0, '0, '0, '0, 8'h02, 8'h02, 1'b0);
            if (k == 3) chk("R6 step not yet", 64'(core_test_q[1]), 64'd0);
            if (k == 4) chk("R6 step arrives", 64'(core_test_q[1]), 64'd1);
        end

        // Random traffic in blocks of fixed loopback and filter choice.
        for (int b = 0; b < 15; b++) begin
            logic lp;
            logic [NP-1:0] sl;
            lp = 1'($urandom);
            sl = (b % 3 == 0) ? '0 : NP'($urandom);
            for (int k = 0; k < 100; k++) begin
                step(NC'($urandom), NC'($urandom), NC'($urandom),
                     {$urandom, $urandom} & ({($urandom % 2 == 0) ? 64'hFFFF_FFFF : 64'h0}),
                     VW'({$urandom}), NP'($urandom), sl, lp);
            end
        end
        repeat (6) idle('0, '0, 1'b0);
        @(negedge clk);
        check_all();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule